// File: doc/BRIEF.md
# Row/Column Multiplexed Dynamic Memory Controller

This block connects a simple host request port to a synthesizable model of a dynamic storage array. Each host address is split into a row part (upper bits) and a column part (lower bits). The two parts go out one after the other on a single shared address bus. A row strobe qualifies the row part and a column strobe qualifies the column part. Opening a row senses the whole row into a line buffer, and the column access then works on that buffer.

In the one-transistor cell variant, sensing a row wipes its stored charge. For that reason every access, and every refresh, ends with a write-back of the line buffer into the row. In the three-transistor variant the cells hold the complement of the data: sensing inverts it and the write-back inverts it again.

An internal timer raises a refresh request at a fixed spacing. The refresh row counter visits every row in turn and wraps to row 0. The array model tracks how long each row has gone since it was last restored. It raises a sticky flag if any row goes a full retention period without a restore.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `dram_ras`, `dram_cas`, `rsp_valid` and `charge_lost` are 0.
- R2: When `dram_ras` rises, `dram_addr` carries the row part `req_addr[ROW_W+COL_W-1:COL_W]`. When `dram_cas` rises, it carries the column part `req_addr[COL_W-1:0]`. `dram_cas` is only high while `dram_ras` is high.
- R3: `dram_cas` rises exactly `RAS_TO_CAS` cycles after `dram_ras` rises.
- R4: For a read, `rsp_valid` pulses for one cycle, one cycle after the column strobe cycle. This is `RAS_TO_CAS+1` cycles after the accepting edge. `rsp_data` holds the addressed word in that cycle. Writes give no `rsp_valid`.
- R5: Data written to an address reads back unchanged. Repeated reads of one address return the same value, because every access restores its row. A write to one column leaves the other columns of that row intact.
- R6: A refresh opens a row with no column strobe. Successive refreshes visit rows 0,1,2,… and wrap from the last row to row 0. A refresh is requested every `RETENTION_CYC/(2*2**ROW_W)` cycles.
- R7: A pending refresh is served before a waiting host request, but never cuts into an access already started. `req_ready` is 0 whenever a row is open.
- R8: No row ever goes `RETENTION_CYC` cycles without a restore. `charge_lost` stays 0 under both host traffic and idle periods.
- R9: With `CELL_KIND=1` (inverted storage, non-destructive sense), the host-visible data and timing are identical to `CELL_KIND=0`.
- R10: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row part in upper bits, column part in lower bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared multiplexed address bus |
| dram_ras | output | 1 | Row strobe |
| dram_cas | output | 1 | Column strobe |
| dram_we | output | 1 | Column access is a write |
| charge_lost | output | 1 | Sticky: some row exceeded the retention period |

## Verification
A full sweep of every address is done twice: once with an incrementing pattern and once with alternating all-zero/all-one words. Together these separate row/column decode faults from stuck data bits. Triple reads of one address, and a write between two neighbouring reads in the same row, show whether the write-back after a destructive sense is in place. A long idle stretch followed by a read-back separates a working refresh from one that only looks busy, while the bus monitor confirms the refresh row order and the strobe spacing. A back-to-back stream, kept up while refreshes are falling due, shows that refresh waits for an access to finish and that access latency never shifts. The inverted-storage variant runs in parallel on the same stimulus.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_RESTORE,
    ST_PRE
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mdc_refresh_timer.sv
module mdc_refresh_timer #(
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned TICK_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == TW'(TICK_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      pending  <= 1'b0;
      row      <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (ack)
        pending <= 1'b0;
      if (ack)
        row <= row + 1'b1;
    end
  end

  // R6: each served refresh moves the row pointer by one, wrapping at the top
  p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> row == ROW_W'($past(row) + 1'b1));

  // R7: a refresh is only started when one was requested
  p_ack_pending_r7: assert property (@(posedge clk) disable iff (rst)
    ack |-> pending);

endmodule

// File: rtl/mdc_sequencer.sv
module mdc_sequencer
  import mdc_pkg::*;
#(
  parameter int unsigned ROW_W      = 4,
  parameter int unsigned COL_W      = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RAS_TO_CAS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   ready,
  output logic                   rsp_valid,
  input  logic                   ref_pending,
  input  logic [ROW_W-1:0]       ref_row,
  output logic                   ref_ack,
  output logic [max_of(ROW_W, COL_W)-1:0] bus_addr,
  output logic                   ras,
  output logic                   cas,
  output logic                   we,
  output logic [DATA_W-1:0]      wdata,
  output logic                   wb
);
  localparam int unsigned ABUS_W = max_of(ROW_W, COL_W);
  localparam int unsigned CW     = $clog2(RAS_TO_CAS + 1);

  seq_state_t         state;
  logic [CW-1:0]      cnt;
  logic               is_ref;
  logic               op_we;
  logic [COL_W-1:0]   op_col;
  logic [CW-1:0]      since_ras;

  assign ready   = (state == ST_IDLE) && !ref_pending;
  assign ref_ack = (state == ST_IDLE) && ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      is_ref    <= 1'b0;
      op_we     <= 1'b0;
      op_col    <= '0;
      wdata     <= '0;
      bus_addr  <= '0;
      ras       <= 1'b0;
      cas       <= 1'b0;
      we        <= 1'b0;
      wb        <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            is_ref   <= 1'b1;
            bus_addr <= ABUS_W'(ref_row);
            ras      <= 1'b1;
            cnt      <= '0;
            state    <= ST_ROW;
          end else if (req_valid) begin
            is_ref   <= 1'b0;
            op_we    <= req_we;
            op_col   <= req_addr[COL_W-1:0];
            wdata    <= req_wdata;
            bus_addr <= ABUS_W'(req_addr[ROW_W+COL_W-1:COL_W]);
            ras      <= 1'b1;
            cnt      <= '0;
            state    <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (cnt == CW'(RAS_TO_CAS - 1)) begin
            if (is_ref) begin
              wb    <= 1'b1;
              state <= ST_RESTORE;
            end else begin
              cas      <= 1'b1;
              we       <= op_we;
              bus_addr <= ABUS_W'(op_col);
              state    <= ST_COL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COL: begin
          cas       <= 1'b0;
          we        <= 1'b0;
          rsp_valid <= !op_we;
          wb        <= 1'b1;
          state     <= ST_RESTORE;
        end
        ST_RESTORE: begin
          wb        <= 1'b0;
          ras       <= 1'b0;
          rsp_valid <= 1'b0;
          state     <= ST_PRE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // cycles since the row strobe rose, saturating; observes strobe spacing
  always_ff @(posedge clk) begin
    if (rst || !ras)
      since_ras <= '0;
    else if (since_ras != CW'(RAS_TO_CAS))
      since_ras <= since_ras + 1'b1;
  end

  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (rst)
    cas |-> ras);

  p_cas_delay_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cas) |-> since_ras == CW'(RAS_TO_CAS));

  p_rsp_after_cas_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(cas) && !$past(we)));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    ras |-> !ready);

  p_accept_opens_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> (ras && !is_ref));

endmodule

// File: rtl/mdc_cell_array.sv
module mdc_cell_array
  import mdc_pkg::*;
#(
  parameter int unsigned ROW_W         = 4,
  parameter int unsigned COL_W         = 3,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CELL_KIND     = 0,
  parameter int unsigned RETENTION_CYC = 2048
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [max_of(ROW_W, COL_W)-1:0] bus_addr,
  input  logic                            ras,
  input  logic                            cas,
  input  logic                            we,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            wb,
  output logic [DATA_W-1:0]               rdata,
  output logic                            charge_lost
);
  localparam int unsigned ROWS   = 1 << ROW_W;
  localparam int unsigned COLS   = 1 << COL_W;
  localparam int unsigned LINE_W = COLS * DATA_W;
  localparam int unsigned AGE_W  = $clog2(RETENTION_CYC + 1);

  logic [LINE_W-1:0] cells [ROWS];
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] sensed;
  logic [LINE_W-1:0] store_val;
  logic              destroy;
  logic              ras_q;
  logic [ROW_W-1:0]  open_row;
  logic [ROW_W-1:0]  bus_row;
  logic [COL_W-1:0]  bus_col;
  logic              open_evt;
  logic [ROWS-1:0]   expired;

  assign bus_row  = bus_addr[ROW_W-1:0];
  assign bus_col  = bus_addr[COL_W-1:0];
  assign open_evt = ras && !ras_q;

  generate
    if (CELL_KIND == 0) begin : g_one_t
      // charge-sharing cell: sensing drains the row, stored polarity true
      assign sensed    = cells[bus_row];
      assign store_val = line;
      assign destroy   = 1'b1;
    end else begin : g_three_t
      // separate read/write ports: read path inverts, sensing keeps the charge
      assign sensed    = ~cells[bus_row];
      assign store_val = ~line;
      assign destroy   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (open_evt && destroy)
      cells[bus_row] <= '0;
    if (wb)
      cells[open_row] <= store_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q    <= 1'b0;
      open_row <= '0;
      line     <= '0;
      rdata    <= '0;
    end else begin
      ras_q <= ras;
      if (open_evt) begin
        open_row <= bus_row;
        line     <= sensed;
      end else if (cas && we) begin
        line[bus_col*DATA_W +: DATA_W] <= wdata;
      end
      if (cas && !we)
        rdata <= line[bus_col*DATA_W +: DATA_W];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (rst)
        age <= '0;
      else if (wb && (open_row == ROW_W'(r)))
        age <= '0;
      else if (age != AGE_W'(RETENTION_CYC))
        age <= age + 1'b1;
    end
    assign expired[r] = (age == AGE_W'(RETENTION_CYC));
  end

  always_ff @(posedge clk) begin
    if (rst)
      charge_lost <= 1'b0;
    else
      charge_lost <= charge_lost | (|expired);
  end

  // R5: a restore is only issued into an open, already sensed row
  p_wb_open_r5: assert property (@(posedge clk) disable iff (rst)
    wb |-> (ras && ras_q));

  // R2: a column access always follows a completed row sense
  p_col_after_sense_r2: assert property (@(posedge clk) disable iff (rst)
    cas |-> ras_q);

  // R8: every row is restored within its retention period
  p_rows_alive_r8: assert property (@(posedge clk) disable iff (rst)
    expired == '0);

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int unsigned ROW_W         = 4,
  parameter int unsigned COL_W         = 3,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned RAS_TO_CAS    = 2,
  parameter int unsigned RETENTION_CYC = 2048,
  parameter int unsigned CELL_KIND     = 0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_we,
  input  logic [ROW_W+COL_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            req_ready,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_data,
  output logic [max_of(ROW_W, COL_W)-1:0] dram_addr,
  output logic                            dram_ras,
  output logic                            dram_cas,
  output logic                            dram_we,
  output logic                            charge_lost
);
  localparam int unsigned ROWS     = 1 << ROW_W;
  localparam int unsigned TICK_CYC = RETENTION_CYC / (2 * ROWS);
  localparam int unsigned ABUS_W   = max_of(ROW_W, COL_W);

  logic              ref_pending;
  logic              ref_ack;
  logic [ROW_W-1:0]  ref_row;
  logic [ABUS_W-1:0] bus_addr;
  logic              ras;
  logic              cas;
  logic              we;
  logic              wb;
  logic [DATA_W-1:0] wdata;

  mdc_refresh_timer #(
    .ROW_W    (ROW_W),
    .TICK_CYC (TICK_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pending (ref_pending),
    .row     (ref_row)
  );

  mdc_sequencer #(
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .DATA_W     (DATA_W),
    .RAS_TO_CAS (RAS_TO_CAS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ready       (req_ready),
    .rsp_valid   (rsp_valid),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_ack     (ref_ack),
    .bus_addr    (bus_addr),
    .ras         (ras),
    .cas         (cas),
    .we          (we),
    .wdata       (wdata),
    .wb          (wb)
  );

  mdc_cell_array #(
    .ROW_W         (ROW_W),
    .COL_W         (COL_W),
    .DATA_W        (DATA_W),
    .CELL_KIND     (CELL_KIND),
    .RETENTION_CYC (RETENTION_CYC)
  ) u_array (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .ras         (ras),
    .cas         (cas),
    .we          (we),
    .wdata       (wdata),
    .wb          (wb),
    .rdata       (rsp_data),
    .charge_lost (charge_lost)
  );

  assign dram_addr = bus_addr;
  assign dram_ras  = ras;
  assign dram_cas  = cas;
  assign dram_we   = we;

endmodule

// File: tb/mux_dram_ctrl_bench.sv
module mux_dram_ctrl_bench;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int DW    = 8;
  localparam int AW    = ROW_W + COL_W;
  localparam int R2C   = 2;
  localparam int RET   = 2048;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int BW    = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_we    = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;

  logic          req_ready, rsp_valid, dram_ras, dram_cas, dram_we, charge_lost;
  logic [DW-1:0] rsp_data;
  logic [BW-1:0] dram_addr;
  logic          i_ready, i_valid, i_ras, i_cas, i_we, i_lost;
  logic [DW-1:0] i_data;
  logic [BW-1:0] i_addr;

  mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .RAS_TO_CAS(R2C),
                  .RETENTION_CYC(RET), .CELL_KIND(0)) u_mux_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we),
    .charge_lost(charge_lost));

  mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .RAS_TO_CAS(R2C),
                  .RETENTION_CYC(RET), .CELL_KIND(1)) u_mux_dram_ctrl_inv (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(i_ready), .rsp_valid(i_valid), .rsp_data(i_data),
    .dram_addr(i_addr), .dram_ras(i_ras), .dram_cas(i_cas), .dram_we(i_we),
    .charge_lost(i_lost));

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bus monitor (ports only) ----------------
  logic          ras_prev = 1'b0, cas_prev = 1'b0;
  int            since = 0;
  logic [BW-1:0] row_seen = '0, last_row = '0, last_col = '0;
  int            exp_ref = 0;
  int            n_ref = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dram_ras && !ras_prev) begin
        since    = 0;
        row_seen = dram_addr;
      end else if (dram_ras) begin
        since++;
      end
      if (dram_ras)
        check(req_ready == 1'b0, "R7 ready low while row open", req_ready, 0);
      if (dram_cas && !dram_ras)
        check(1'b0, "R2 column strobe outside row strobe", dram_cas, 0);
      if (dram_cas && !cas_prev) begin
        check(since == R2C, "R3 row-to-column spacing", since, R2C);
        last_row = row_seen;
        last_col = dram_addr;
      end
      if (dram_ras && since == R2C && !dram_cas) begin
        check(row_seen == BW'(exp_ref), "R6 refresh row order", row_seen, exp_ref);
        exp_ref = (exp_ref + 1) % ROWS;
        n_ref++;
      end
      if (i_ready !== req_ready || i_ras !== dram_ras || i_cas !== dram_cas)
        check(1'b0, "R9 variant timing mismatch", {i_ready, i_ras, i_cas}, {req_ready, dram_ras, dram_cas});
      ras_prev = dram_ras;
      cas_prev = dram_cas;
    end
  end

  // ---------------- access helper ----------------
  task automatic do_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [DW-1:0] q);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10 ready drops after accept", req_ready, 0);
    n = 0;
    if (we) begin
      repeat (R2C + 1) begin
        @(negedge clk);
        n++;
        if (rsp_valid) check(1'b0, "R4 rsp_valid on write", 1, 0);
      end
    end else begin
      while (!rsp_valid && n < 50) begin
        @(negedge clk);
        n++;
      end
      check(n == R2C + 1, "R4 read latency", n, R2C + 1);
      check(i_data == rsp_data, "R9 inverted variant data", i_data, rsp_data);
    end
    q = rsp_data;
    check(last_row == BW'(a[AW-1:COL_W]), "R2 row part on bus", last_row, a[AW-1:COL_W]);
    check(last_col == BW'(a[COL_W-1:0]), "R2 column part on bus", last_col, a[COL_W-1:0]);
  endtask

  function automatic logic [DW-1:0] pat_a(input int a);
    return DW'(a * 37 + 11);
  endfunction

  function automatic logic [DW-1:0] pat_b(input int a);
    return (a[0] ^ a[COL_W]) ? 8'hFF : 8'h00;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(dram_ras == 1'b0 && dram_cas == 1'b0, "R1 strobes idle", {dram_ras, dram_cas}, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", rsp_valid, 0);
    check(charge_lost == 1'b0, "R1 charge_lost clear", charge_lost, 0);
  endtask

  task automatic t_sweep(input bit use_b);
    logic [DW-1:0] q;
    for (int a = 0; a < ROWS * COLS; a++)
      do_access(1'b1, AW'(a), use_b ? pat_b(a) : pat_a(a), q);
    for (int a = ROWS * COLS - 1; a >= 0; a--) begin
      do_access(1'b0, AW'(a), '0, q);
      check(q == (use_b ? pat_b(a) : pat_a(a)), "R5 sweep read-back", q, use_b ? pat_b(a) : pat_a(a));
    end
  endtask

  task automatic t_destructive_read();
    logic [DW-1:0] q;
    logic [AW-1:0] a = {4'd9, 3'd5};
    do_access(1'b1, a, 8'hC3, q);
    for (int k = 0; k < 3; k++) begin
      do_access(1'b0, a, '0, q);
      check(q == 8'hC3, "R5 repeated read keeps value", q, 8'hC3);
    end
    do_access(1'b1, {4'd9, 3'd4}, 8'h5A, q);
    do_access(1'b0, a, '0, q);
    check(q == 8'hC3, "R5 neighbour column intact", q, 8'hC3);
    do_access(1'b0, {4'd9, 3'd4}, '0, q);
    check(q == 8'h5A, "R5 neighbour write lands", q, 8'h5A);
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] q;
    int ref0 = n_ref;
    for (int k = 0; k < 120; k++) begin
      do_access(1'b0, AW'(k * 5), '0, q);
      check(q == pat_b(k * 5), "R7 data under refresh contention", q, pat_b(k * 5));
    end
    check(n_ref > ref0, "R7 refresh served during traffic", n_ref - ref0, 1);
    check(charge_lost == 1'b0, "R8 no expiry under traffic", charge_lost, 0);
  endtask

  task automatic t_idle_retention();
    logic [DW-1:0] q;
    int ref0 = n_ref;
    repeat (3 * RET / 2 + 500) @(negedge clk);
    check(n_ref - ref0 >= 40, "R6 refresh keeps running when idle", n_ref - ref0, 40);
    check(charge_lost == 1'b0, "R8 no expiry when idle", charge_lost, 0);
    check(i_lost == 1'b0, "R8 no expiry inverted variant", i_lost, 0);
    for (int a = 0; a < ROWS * COLS; a += 3) begin
      do_access(1'b0, AW'(a), '0, q);
      check(q == pat_b(a), "R8 data survives idle", q, pat_b(a));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_sweep(1'b0);
    t_destructive_read();
    t_sweep(1'b1);
    t_back_to_back();
    t_idle_retention();
    check(charge_lost == 1'b0, "R8 final charge state", charge_lost, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired (R10 progress) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule